// File: doc/BRIEF.md
# Interrupt Pin Sensing and End-of-Interrupt Engine

This block turns a bank of interrupt input lines into delivery messages. Each pin has its own routing entry: vector, delivery mode, destination mode, input polarity, trigger type, mask and destination. For each pin the block keeps a request bit that follows the polarity-corrected input level. Edge pins are serviced on each rise of that level. Level pins are serviced only while their remote in-service flag is clear. An assertion that cannot be delivered because the flag is still set is reported as coalesced. Delivery messages leave through a single valid/ready port. When several pins are waiting, the lowest-numbered pin goes first.

End-of-interrupt messages carry a vector and a trigger type. A 256-bit map marks every vector that appears in any entry, and an EOI whose vector is not marked is dropped. An accepted EOI starts a scan that visits one pin per clock. For each pin whose vector matches, the scan emits an acknowledge. A level-type EOI also clears that pin's remote flag and requests delivery again if the pin is unmasked and its request bit is still set. Entries are loaded whole through a write port. A write clears the pin's remote flag and re-services a level pin whose request bit is set.

Top module: `irq_sense_eoi`

## Requirements
- R1: After reset every entry is masked. No delivery, acknowledge or coalesced pulse appears, and the EOI busy flag is low.
- R2: The effective level of a pin is its raw input XOR the polarity bit (wr_entry[12]). A rise of the effective level is the pin's event; raw input changes that do not raise the effective level produce no delivery.
- R3: An edge pin (wr_entry[13]=0) that is unmasked produces one delivery per rise of its effective level. Holding the level high produces no further delivery.
- R4: A level pin (wr_entry[13]=1) whose remote flag is clear produces one delivery on its event, and issuing that delivery sets the remote flag. An event while the flag is set produces no delivery and pulses that pin's bit of coal_mask for one cycle.
- R5: A pin whose mask bit (wr_entry[14]) is set produces no delivery on its events.
- R6: A delivery carries the entry's vector (wr_entry[7:0]), delivery mode (wr_entry[10:8]), destination mode (wr_entry[11]), trigger type and destination (wr_entry[22:15]). Waiting pins are issued lowest index first. The message is held unchanged while dlv_ready is low.
- R7: An EOI whose vector is in no entry is ignored: eoi_busy stays low and no acknowledge appears.
- R8: An accepted EOI keeps eoi_busy high for exactly NPINS cycles. It emits one acknowledge for each pin whose vector matches, in ascending pin order.
- R9: A level-type EOI clears the remote flag of each matching pin and redelivers it if it is unmasked and its input is still active. An edge-type EOI leaves the remote flag set.
- R10: Writing an entry clears the pin's remote flag. If the new entry is level-triggered, unmasked and the pin's request bit is set, the pin is delivered again.
- R11: With PIN0_PHYS set, every delivery from pin 0 has destination mode 0 and destination BSP_ID.
- R12: Pin events arriving while an EOI scan is running are still recorded and delivered during the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | NPINS | Raw interrupt input levels |
| wr_en | input | 1 | Load an entry |
| wr_pin | input | PW | Pin whose entry is loaded |
| wr_entry | input | 23 | Entry: [7:0] vector, [10:8] delivery mode, [11] dest mode, [12] polarity, [13] level trigger, [14] mask, [22:15] destination |
| eoi_valid | input | 1 | EOI message present, taken when eoi_busy is low |
| eoi_vector | input | 8 | EOI vector |
| eoi_level | input | 1 | EOI of level type |
| eoi_busy | output | 1 | EOI scan in progress |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_ready | input | 1 | Receiver takes the message |
| dlv_pin | output | PW | Originating pin |
| dlv_vector | output | 8 | Vector |
| dlv_dest | output | 8 | Destination ID |
| dlv_dest_mode | output | 1 | Destination mode |
| dlv_trig | output | 1 | Trigger type, 1 = level |
| dlv_mode | output | 3 | Delivery mode |
| coal_mask | output | NPINS | One-cycle coalesced pulse per pin |
| ack_valid | output | 1 | Acknowledge for one matching pin |
| ack_pin | output | PW | Pin being acknowledged |

## Verification
Several checks run on every cycle. A stalled message must stay unchanged. A coalesced pulse may appear only on a pin whose remote flag was set. Acknowledges appear only during a scan. The scan index advances by one each busy cycle, and an unmarked EOI cannot start a scan. The pin-0 override is also checked on every delivery. Other behaviours only show up through the bench's scenarios: polarity inversion, the lowest-index order, redelivery after a level EOI or a rewrite, and deliveries that overlap a scan. These depend on sequences of pin, write and EOI activity.

// File: rtl/irqse_pkg.sv
`timescale 1ns/1ps
package irqse_pkg;
    localparam int VEC_W   = 8;
    localparam int NVEC    = 1 << VEC_W;
    localparam int RTE_W   = 23;

    // Routing entry; field placement defines the wr_entry layout
    typedef struct packed {
        logic [7:0]       dest;
        logic             mask;
        logic             lvl;
        logic             pol;
        logic             dmode;
        logic [2:0]       dlv;
        logic [VEC_W-1:0] vector;
    } rte_t;

    localparam rte_t RTE_RESET = '{dest: '0, mask: 1'b1, lvl: 1'b0, pol: 1'b0,
                                   dmode: 1'b0, dlv: '0, vector: '0};
endpackage

// File: rtl/irqse_vecmap.sv
`timescale 1ns/1ps
module irqse_vecmap
    import irqse_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  rte_t [NPINS-1:0]       tbl,
    output logic [NVEC-1:0]        map_q
);
    logic [NVEC-1:0] map_d;

    always_comb begin
        map_d = '0;
        for (int i = 0; i < NPINS; i++) begin
            map_d[tbl[i].vector] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end
endmodule

// File: rtl/irqse_pick.sv
`timescale 1ns/1ps
module irqse_pick #(
    parameter int NPINS = 24,
    localparam int PW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic [NPINS-1:0] req,
    output logic             any,
    output logic [PW-1:0]    idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = PW'(i);
            end
        end
    end
endmodule

// File: rtl/irqse_eoi_scan.sv
`timescale 1ns/1ps
module irqse_eoi_scan
    import irqse_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int PW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             eoi_level,
    input  logic [NVEC-1:0]  map,
    input  logic [VEC_W-1:0] cur_vec,
    output logic             busy,
    output logic [PW-1:0]    idx,
    output logic             hit,
    output logic             hit_lvl
);
    localparam logic [PW-1:0] LAST = PW'(NPINS - 1);

    typedef struct packed {
        logic             busy;
        logic [PW-1:0]    idx;
        logic [VEC_W-1:0] vec;
        logic             lvl;
    } scan_t;

    scan_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.idx == LAST) s_d.busy = 1'b0;
            else                 s_d.idx  = s_q.idx + PW'(1);
        end else if (eoi_valid && map[eoi_vector]) begin
            s_d.busy = 1'b1;
            s_d.idx  = '0;
            s_d.vec  = eoi_vector;
            s_d.lvl  = eoi_level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign idx     = s_q.idx;
    assign hit     = s_q.busy && (cur_vec == s_q.vec);
    assign hit_lvl = s_q.lvl;

    // R8: one pin visited per busy cycle
    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && s_q.idx != LAST |=> s_q.busy && s_q.idx == $past(s_q.idx) + PW'(1));

    // R7: an unmarked vector never starts a scan
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy && !(eoi_valid && map[eoi_vector]) |=> !s_q.busy);
endmodule

// File: rtl/irq_sense_eoi.sv
`timescale 1ns/1ps
module irq_sense_eoi
    import irqse_pkg::*;
#(
    parameter int         NPINS     = 24,
    parameter bit         PIN0_PHYS = 1'b1,
    parameter logic [7:0] BSP_ID    = 8'h00,
    localparam int        PW        = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_raw,
    input  logic             wr_en,
    input  logic [PW-1:0]    wr_pin,
    input  logic [RTE_W-1:0] wr_entry,
    input  logic             eoi_valid,
    input  logic [7:0]       eoi_vector,
    input  logic             eoi_level,
    output logic             eoi_busy,
    output logic             dlv_valid,
    input  logic             dlv_ready,
    output logic [PW-1:0]    dlv_pin,
    output logic [7:0]       dlv_vector,
    output logic [7:0]       dlv_dest,
    output logic             dlv_dest_mode,
    output logic             dlv_trig,
    output logic [2:0]       dlv_mode,
    output logic [NPINS-1:0] coal_mask,
    output logic             ack_valid,
    output logic [PW-1:0]    ack_pin
);
    typedef struct packed {
        rte_t [NPINS-1:0] tbl;
        logic [NPINS-1:0] irr;
        logic [NPINS-1:0] rirr;
        logic [NPINS-1:0] pend;
        logic [NPINS-1:0] coal;
        logic             dv;
        rte_t             dmsg;
        logic [PW-1:0]    dpin;
        logic             ack_v;
        logic [PW-1:0]    ack_p;
    } st_t;

    st_t s_d, s_q;

    logic [NPINS-1:0] eff, evt, mask_v;
    logic [NVEC-1:0]  vmap;
    logic             pick_any;
    logic [PW-1:0]    pick_idx;
    logic             force0;
    logic             scan_busy, scan_hit, scan_lvl;
    logic [PW-1:0]    scan_idx;
    logic [VEC_W-1:0] scan_vec;
    rte_t             wr_rte;

    assign wr_rte   = rte_t'(wr_entry);
    assign scan_vec = s_q.tbl[scan_idx].vector;

    irqse_vecmap #(.NPINS(NPINS)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .tbl   (s_q.tbl),
        .map_q (vmap)
    );

    irqse_pick #(.NPINS(NPINS)) u_pick (
        .req (s_q.pend & ~mask_v),
        .any (pick_any),
        .idx (pick_idx)
    );

    irqse_eoi_scan #(.NPINS(NPINS)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .eoi_level  (eoi_level),
        .map        (vmap),
        .cur_vec    (scan_vec),
        .busy       (scan_busy),
        .idx        (scan_idx),
        .hit        (scan_hit),
        .hit_lvl    (scan_lvl)
    );

    generate
        if (PIN0_PHYS) begin : g_pin0_fixed
            assign force0 = (pick_idx == '0);
        end else begin : g_pin0_free
            assign force0 = 1'b0;
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            eff[i]    = pin_raw[i] ^ s_q.tbl[i].pol;
            mask_v[i] = s_q.tbl[i].mask;
        end
        evt = eff & ~s_q.irr;
    end

    always_comb begin
        s_d      = s_q;
        s_d.irr  = eff;
        s_d.coal = '0;

        // issue stage: load the output register when it is free
        if (!s_q.dv || dlv_ready) begin
            s_d.dv = pick_any;
            if (pick_any) begin
                s_d.dmsg = s_q.tbl[pick_idx];
                s_d.dpin = pick_idx;
                if (force0) begin
                    s_d.dmsg.dmode = 1'b0;
                    s_d.dmsg.dest  = BSP_ID;
                end
                s_d.pend[pick_idx] = 1'b0;
                if (s_q.tbl[pick_idx].lvl) s_d.rirr[pick_idx] = 1'b1;
            end
        end

        // pin events
        for (int i = 0; i < NPINS; i++) begin
            if (evt[i]) begin
                if (s_q.tbl[i].lvl && s_q.rirr[i]) s_d.coal[i] = 1'b1;
                else if (!s_q.tbl[i].mask)         s_d.pend[i] = 1'b1;
            end
        end
        s_d.pend = s_d.pend & ~mask_v;

        // EOI scan step
        s_d.ack_v = scan_hit;
        s_d.ack_p = scan_idx;
        if (scan_hit && scan_lvl) begin
            s_d.rirr[scan_idx] = 1'b0;
            if (!s_q.tbl[scan_idx].mask && s_q.irr[scan_idx])
                s_d.pend[scan_idx] = 1'b1;
        end

        // entry rewrite
        if (wr_en && int'(wr_pin) < NPINS) begin
            s_d.tbl[wr_pin]  = wr_rte;
            s_d.rirr[wr_pin] = 1'b0;
            if (wr_rte.lvl && !wr_rte.mask && s_q.irr[wr_pin])
                s_d.pend[wr_pin] = 1'b1;
            else if (wr_rte.mask)
                s_d.pend[wr_pin] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < NPINS; i++) s_q.tbl[i] <= RTE_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign eoi_busy      = scan_busy;
    assign dlv_valid     = s_q.dv;
    assign dlv_pin       = s_q.dpin;
    assign dlv_vector    = s_q.dmsg.vector;
    assign dlv_dest      = s_q.dmsg.dest;
    assign dlv_dest_mode = s_q.dmsg.dmode;
    assign dlv_trig      = s_q.dmsg.lvl;
    assign dlv_mode      = s_q.dmsg.dlv;
    assign coal_mask     = s_q.coal;
    assign ack_valid     = s_q.ack_v;
    assign ack_pin       = s_q.ack_p;

    // R6: stalled message holds
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_pin) && $stable(dlv_vector)
                                    && $stable(dlv_dest) && $stable(dlv_mode));

    // R4: coalescing only on pins whose remote flag was set
    p_coal_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_q.coal) |-> ((s_q.coal & ~$past(s_q.rirr)) == '0));

    // R8: acknowledges only come from a running scan
    p_ack_in_scan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(scan_busy));

    generate
        if (PIN0_PHYS) begin : g_chk_pin0
            // R11: pin 0 routed to the boot processor in physical mode
            p_pin0_r11: assert property (@(posedge clk) disable iff (!rst_n)
                dlv_valid && dlv_pin == '0 |-> !dlv_dest_mode && dlv_dest == BSP_ID);
        end
    endgenerate
endmodule

// File: tb/irq_sense_eoi_test.sv
`timescale 1ns/1ps
module irq_sense_eoi_test;
    localparam int N  = 8;
    localparam int PW = 3;
    localparam logic [7:0] BSP = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pin_raw = '0;
    logic wr_en = 1'b0;
    logic [PW-1:0] wr_pin = '0;
    logic [22:0] wr_entry = '0;
    logic eoi_valid = 1'b0;
    logic [7:0] eoi_vector = '0;
    logic eoi_level = 1'b0;
    logic eoi_busy, dlv_valid, dlv_dest_mode, dlv_trig, ack_valid;
    logic dlv_ready = 1'b1;
    logic [PW-1:0] dlv_pin, ack_pin;
    logic [7:0] dlv_vector, dlv_dest;
    logic [2:0] dlv_mode;
    logic [N-1:0] coal_mask;

    always #2.5 clk = ~clk;

    irq_sense_eoi #(.NPINS(N), .PIN0_PHYS(1'b1), .BSP_ID(BSP)) uut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .wr_en(wr_en), .wr_pin(wr_pin),
        .wr_entry(wr_entry), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .eoi_level(eoi_level), .eoi_busy(eoi_busy), .dlv_valid(dlv_valid),
        .dlv_ready(dlv_ready), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
        .dlv_dest(dlv_dest), .dlv_dest_mode(dlv_dest_mode), .dlv_trig(dlv_trig),
        .dlv_mode(dlv_mode), .coal_mask(coal_mask), .ack_valid(ack_valid), .ack_pin(ack_pin)
    );

    int tests = 0, fails = 0;
    int dcnt[N], acnt[N], ccnt[N];
    int lvec[N], ldest[N], ldm[N], lmode[N], ltrig[N];
    int seq[64], aseq[64];
    int seqn = 0, an = 0, busyc = 0;
    bit dur_busy = 0, done = 0;

    always @(negedge clk) if (rst_n) begin
        if (dlv_valid && dlv_ready) begin
            dcnt[dlv_pin]++;
            lvec[dlv_pin] = dlv_vector; ldest[dlv_pin] = dlv_dest;
            ldm[dlv_pin] = dlv_dest_mode; lmode[dlv_pin] = dlv_mode; ltrig[dlv_pin] = dlv_trig;
            if (seqn < 64) seq[seqn] = dlv_pin;
            seqn++;
            if (eoi_busy) dur_busy = 1;
        end
        if (ack_valid) begin
            acnt[ack_pin]++;
            if (an < 64) aseq[an] = ack_pin;
            an++;
        end
        for (int i = 0; i < N; i++) ccnt[i] += coal_mask[i];
        if (eoi_busy) busyc++;
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [22:0] mk(input logic [7:0] vec, input logic [2:0] dl,
        input logic dm, input logic pol, input logic lvl, input logic msk, input logic [7:0] dst);
        return {dst, msk, lvl, pol, dm, dl, vec};
    endfunction

    task automatic wr(input int p, input logic [22:0] e);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_pin = PW'(p); wr_entry = e;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v, input logic lvl);
        @(posedge clk); #1;
        eoi_valid = 1'b1; eoi_vector = v; eoi_level = lvl;
        @(posedge clk); #1;
        eoi_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int b, c;
        for (int i = 0; i < N; i++) begin dcnt[i] = 0; acnt[i] = 0; ccnt[i] = 0; end
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state, all entries masked
        check("R1 dlv_valid", dlv_valid, 0);
        check("R1 busy", eoi_busy, 0);
        pin_raw = '1;
        tick(6);
        b = 0; c = 0;
        for (int i = 0; i < N; i++) begin b += dcnt[i]; c += ccnt[i]; end
        check("R1 R5 no delivery from masked pins", b, 0);
        check("R1 no coalesced", c, 0);
        pin_raw = '0;
        tick(3);

        // R3 R6 R11: program every pin edge-triggered and sweep
        for (int i = 0; i < N; i++)
            wr(i, mk(8'h20 + 8'(i), 3'(i), 1'b1, 1'b0, 1'b0, 1'b0, 8'h10 + 8'(i)));
        tick(2);
        for (int i = 0; i < N; i++) begin
            pin_raw[i] = 1'b1; tick(5);
            check($sformatf("R3 first edge pin%0d", i), dcnt[i], 1);
            check("R6 vector", lvec[i], 32'h20 + i);
            check("R6 mode", lmode[i], i % 8);
            check("R6 trig", ltrig[i], 0);
            if (i == 0) begin
                check("R11 dest", ldest[i], BSP);
                check("R11 dmode", ldm[i], 0);
            end else begin
                check("R6 dest", ldest[i], 32'h10 + i);
                check("R6 dmode", ldm[i], 1);
            end
            tick(4);
            check("R3 held high no repeat", dcnt[i], 1);
            pin_raw[i] = 1'b0; tick(2);
            pin_raw[i] = 1'b1; tick(5);
            check("R3 second edge", dcnt[i], 2);
            pin_raw[i] = 1'b0; tick(2);
        end

        // R6: priority and stall
        dlv_ready = 1'b0;
        pin_raw[6] = 1'b1; pin_raw[5] = 1'b1; pin_raw[3] = 1'b1;
        tick(4);
        check("R6 valid under stall", dlv_valid, 1);
        check("R6 lowest first", dlv_pin, 3);
        b = dlv_vector;
        tick(3);
        check("R6 stable vector", dlv_vector, b);
        c = seqn;
        dlv_ready = 1'b1;
        tick(8);
        check("R6 order 1st", seq[c], 3);
        check("R6 order 2nd", seq[c+1], 5);
        check("R6 order 3rd", seq[c+2], 6);
        pin_raw = '0; tick(2);

        // R2: polarity inversion on pin 2
        b = dcnt[2];
        pin_raw[2] = 1'b1; tick(5);
        check("R2 raw rise pol0", dcnt[2], b + 1);
        wr(2, mk(8'h22, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'h12));
        tick(4);
        check("R2 pol flip no event", dcnt[2], b + 1);
        pin_raw[2] = 1'b0; tick(5);
        check("R2 raw fall pol1 delivers", dcnt[2], b + 2);

        // R4: level pin 4, pin 7 shares its vector (edge)
        wr(7, mk(8'h44, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h17));
        wr(4, mk(8'h44, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h14));
        tick(2);
        b = dcnt[4];
        pin_raw[4] = 1'b1; tick(5);
        check("R4 level delivery", dcnt[4], b + 1);
        check("R4 trig field", ltrig[4], 1);
        pin_raw[4] = 1'b0; tick(2);
        c = ccnt[4];
        pin_raw[4] = 1'b1; tick(5);
        check("R4 no delivery while in service", dcnt[4], b + 1);
        check("R4 coalesced pulse", ccnt[4], c + 1);

        // R7: unmarked vector
        busyc = 0; c = an;
        eoi(8'h99, 1'b1); tick(12);
        check("R7 not busy", busyc, 0);
        check("R7 no ack", an, c);

        // R8 R9: level EOI
        busyc = 0; c = an; b = dcnt[4];
        eoi(8'h44, 1'b1); tick(14);
        check("R8 busy length", busyc, N);
        check("R8 ack count", an - c, 2);
        check("R8 ack first", aseq[c], 4);
        check("R8 ack second", aseq[c+1], 7);
        check("R9 level redelivery", dcnt[4], b + 1);
        check("R9 edge pin idle", dcnt[7], 2);

        // R9: edge EOI keeps the flag
        b = dcnt[4];
        eoi(8'h44, 1'b0); tick(14);
        check("R9 edge eoi no redelivery", dcnt[4], b);
        pin_raw[4] = 1'b0; tick(2);
        c = ccnt[4];
        pin_raw[4] = 1'b1; tick(5);
        check("R9 still coalesced", ccnt[4], c + 1);
        check("R9 still no delivery", dcnt[4], b);

        // R10: rewrite re-services
        wr(4, mk(8'h44, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h14));
        tick(5);
        check("R10 rewrite redelivers", dcnt[4], b + 1);

        // R12: events during a scan
        pin_raw[4] = 1'b0; tick(2);
        b = dcnt[4]; c = dcnt[1]; dur_busy = 0;
        eoi(8'h44, 1'b1);
        tick(1);
        pin_raw[1] = 1'b1;
        tick(14);
        check("R12 delivery during scan", dcnt[1], c + 1);
        check("R12 overlapped busy", dur_busy, 1);
        check("R9 inactive input no redelivery", dcnt[4], b);
        pin_raw[4] = 1'b1; tick(5);
        check("R9 flag cleared then delivers", dcnt[4], b + 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule